// File: doc/BRIEF.md
# Call/Return Tracker with Guards

This block sits beside a processor and passively watches two event streams: the instruction words being fetched, and a strobe that fires whenever the processor writes its dedicated return-address register. It recognises call and return instructions by comparing each fetched word against a mask/match pair per instruction kind, set by parameters so the same block fits different instruction encodings. Each call pushes a frame record (the return address and a start timestamp) onto an internal shadow history. Each return pops the newest record.

Two guards use that history. A write to the return-address register that is not caused by a call fetched in the same cycle raises an alarm, which catches return-pointer substitution. A per-function deadline raises a timeout alarm when the newest frame has been open longer than the limit on the `cfg_limit` input. Only the newest frame is checked, and a caller's deadline is not checked while one of its callees runs. Time is counted on the block's own clock. Every alarm is a one-cycle pulse that carries a cause code.

Top module: `cr_guard`

## Requirements
- R1: A valid fetch whose word satisfies `(insn & 0x7F) == 0x6F` (default call pattern) is a call. If fewer than 16 frames are open, it pushes a frame on the next clock edge: `depth` rises by one and `top_ret` becomes the fetch address plus 4.
- R2: A valid fetch whose word equals `0x00008067` (default return pattern) is a return. If it is not a call and at least one frame is open, it pops the newest frame on the next edge: `depth` falls by one and `top_ret` shows the frame beneath, or 0 when the history is empty.
- R3: A call that arrives while 16 frames are open leaves the history unchanged and raises an alarm pulse with cause 2 (overflow). `depth` never exceeds 16.
- R4: A return that arrives while the history is empty leaves `depth` at 0 and raises an alarm pulse with cause 3 (underflow).
- R5: A return-address-register write event in a cycle without a call fetch raises an alarm pulse with cause 0 (bad write). The same event in the cycle of a call fetch raises no alarm.
- R6: When the newest frame's elapsed time (current timestamp minus its start timestamp, modulo 2^16) exceeds `cfg_limit`, an alarm pulse with cause 1 (timeout) is raised once for that frame. For a frame pushed at edge k with no later fetch events, the pulse is visible after edge k+L+1, where L is the limit. Cycles that carry an accepted call or return do not evaluate the deadline.
- R7: While a callee is open, its caller's deadline is not checked. After the callee returns, the caller is checked again against its own original start time.
- R8: When several alarm causes coincide, one pulse is reported in this priority order: overflow or underflow, then bad write, then timeout. A timeout that is passed over is reported in the next cycle in which it still holds.
- R9: Fetches that match neither pattern, and cycles with `fetch_valid` low, leave `depth` and `top_ret` unchanged.
- R10: After reset, `depth` is 0, `top_ret` is 0, no alarm is raised, and the timestamp restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Observer clock; also the time base |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetched instruction word is present |
| fetch_insn | input | 32 | Fetched instruction word |
| fetch_pc | input | 32 | Address of the fetched word |
| ra_wr_valid | input | 1 | The return-address register is being written |
| cfg_limit | input | 16 | Per-function execution-time limit in clock cycles |
| alarm_valid | output | 1 | One-cycle alarm pulse |
| alarm_cause | output | 2 | 0 bad write, 1 timeout, 2 overflow, 3 underflow |
| depth | output | 5 | Number of open frames |
| top_ret | output | 32 | Return address of the newest frame, 0 if none |

## Verification
Every alarm, and every change of `depth` or `top_ret`, becomes visible after the clock edge that samples the causing fetch or write event. The exception is the timeout, which appears L+1 edges after the push edge, because the elapsed count must first exceed the limit and is then registered. The bench drives each event half a period before an edge and compares all four outputs against a queue-based reference model part of a period after that edge. Each cycle's outputs therefore belong to exactly one stimulus. Directed checks also count the cycles from a call to its timeout pulse, to confirm that the pulse lands on the expected cycle.

// File: rtl/cr_guard_pkg.sv
package cr_guard_pkg;

    typedef enum logic [1:0] {
        CAUSE_BAD_RA    = 2'd0,
        CAUSE_TIMEOUT   = 2'd1,
        CAUSE_OVERFLOW  = 2'd2,
        CAUSE_UNDERFLOW = 2'd3
    } cause_e;

    typedef struct packed {
        logic   hit;
        cause_e cause;
    } alarm_t;

endpackage

// File: rtl/cr_decode.sv
module cr_decode #(
    parameter int          IW         = 32,
    parameter logic [IW-1:0] CALL_MASK  = 32'h0000_007F,
    parameter logic [IW-1:0] CALL_MATCH = 32'h0000_006F,
    parameter logic [IW-1:0] RET_MASK   = 32'hFFFF_FFFF,
    parameter logic [IW-1:0] RET_MATCH  = 32'h0000_8067
) (
    input  logic          fetch_valid,
    input  logic [IW-1:0] insn,
    output logic          call_hit,
    output logic          ret_hit
);

    logic call_pat;
    logic ret_pat;

    always_comb begin
        call_pat = ((insn & CALL_MASK) == CALL_MATCH);
        ret_pat  = ((insn & RET_MASK) == RET_MATCH);
        call_hit = fetch_valid & call_pat;
        // a word matching both patterns counts as a call only
        ret_hit  = fetch_valid & ret_pat & ~call_pat;
    end

endmodule

// File: rtl/cr_timebase.sv
module cr_timebase #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] now
);

    typedef struct packed {
        logic [TW-1:0] now;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.now = s_q.now + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign now = s_q.now;

endmodule

// File: rtl/cr_history.sv
module cr_history #(
    parameter int AW    = 32,
    parameter int TW    = 16,
    parameter int DEPTH = 16,
    localparam int DW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          mark,
    input  logic [AW-1:0] push_ret,
    input  logic [TW-1:0] push_start,
    output logic [DW:0]   depth,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] top_ret,
    output logic [TW-1:0] top_start,
    output logic          top_expired
);

    localparam logic [DW:0] FULL_CNT = (DW+1)'(DEPTH);

    typedef struct packed {
        logic [DW:0] depth;
    } hist_state_t;

    hist_state_t s_d, s_q;

    logic [AW-1:0] ret_q   [DEPTH];
    logic [TW-1:0] start_q [DEPTH];
    logic          exp_q   [DEPTH];

    logic          wr_en;
    logic [DW-1:0] wr_idx;
    logic [AW-1:0] wr_ret;
    logic [TW-1:0] wr_start;
    logic          wr_exp;
    logic [DW-1:0] top_idx;

    always_comb begin
        top_idx  = DW'(s_q.depth - 1'b1);
        s_d      = s_q;
        wr_en    = 1'b0;
        wr_idx   = DW'(s_q.depth);
        wr_ret   = push_ret;
        wr_start = push_start;
        wr_exp   = 1'b0;
        if (push && !full) begin
            wr_en     = 1'b1;
            s_d.depth = s_q.depth + 1'b1;
        end else if (pop && !empty) begin
            s_d.depth = s_q.depth - 1'b1;
        end else if (mark && !empty) begin
            wr_en    = 1'b1;
            wr_idx   = top_idx;
            wr_ret   = ret_q[top_idx];
            wr_start = start_q[top_idx];
            wr_exp   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ret_q[g]   <= '0;
                start_q[g] <= '0;
                exp_q[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == DW'(g))) begin
                ret_q[g]   <= wr_ret;
                start_q[g] <= wr_start;
                exp_q[g]   <= wr_exp;
            end
        end
    end

    assign depth       = s_q.depth;
    assign full        = (s_q.depth == FULL_CNT);
    assign empty       = (s_q.depth == '0);
    assign top_ret     = empty ? '0 : ret_q[top_idx];
    assign top_start   = empty ? '0 : start_q[top_idx];
    assign top_expired = empty ? 1'b0 : exp_q[top_idx];

endmodule

// File: rtl/cr_guard.sv
module cr_guard
    import cr_guard_pkg::*;
#(
    parameter int            AW         = 32,
    parameter int            IW         = 32,
    parameter int            TW         = 16,
    parameter int            DEPTH      = 16,
    parameter int            RA_STEP    = 4,
    parameter logic [IW-1:0] CALL_MASK  = 32'h0000_007F,
    parameter logic [IW-1:0] CALL_MATCH = 32'h0000_006F,
    parameter logic [IW-1:0] RET_MASK   = 32'hFFFF_FFFF,
    parameter logic [IW-1:0] RET_MATCH  = 32'h0000_8067,
    localparam int           DW         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [IW-1:0] fetch_insn,
    input  logic [AW-1:0] fetch_pc,
    input  logic          ra_wr_valid,
    input  logic [TW-1:0] cfg_limit,
    output logic          alarm_valid,
    output logic [1:0]    alarm_cause,
    output logic [DW:0]   depth,
    output logic [AW-1:0] top_ret
);

    typedef struct packed {
        alarm_t alarm;
    } guard_state_t;

    guard_state_t s_d, s_q;

    logic          call_hit;
    logic          ret_hit;
    logic [TW-1:0] now;
    logic          full;
    logic          empty;
    logic [TW-1:0] top_start;
    logic          top_expired;
    logic [TW-1:0] elapsed;
    logic          ovf;
    logic          unf;
    logic          bad_wr;
    logic          late;
    logic          mark;
    logic [AW-1:0] ret_addr;

    cr_decode #(
        .IW        (IW),
        .CALL_MASK (CALL_MASK),
        .CALL_MATCH(CALL_MATCH),
        .RET_MASK  (RET_MASK),
        .RET_MATCH (RET_MATCH)
    ) u_decode (
        .fetch_valid(fetch_valid),
        .insn       (fetch_insn),
        .call_hit   (call_hit),
        .ret_hit    (ret_hit)
    );

    cr_timebase #(
        .TW(TW)
    ) u_time (
        .clk  (clk),
        .rst_n(rst_n),
        .now  (now)
    );

    cr_history #(
        .AW   (AW),
        .TW   (TW),
        .DEPTH(DEPTH)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (call_hit),
        .pop        (ret_hit),
        .mark       (mark),
        .push_ret   (ret_addr),
        .push_start (now),
        .depth      (depth),
        .full       (full),
        .empty      (empty),
        .top_ret    (top_ret),
        .top_start  (top_start),
        .top_expired(top_expired)
    );

    always_comb begin
        ret_addr = fetch_pc + AW'(RA_STEP);
        elapsed  = now - top_start;
        ovf      = call_hit & full;
        unf      = ret_hit & empty;
        bad_wr   = ra_wr_valid & ~call_hit;
        // deadline only on the newest frame, and only in cycles without call/return
        late     = ~call_hit & ~ret_hit & ~empty & ~top_expired & (elapsed > cfg_limit);
        mark     = 1'b0;

        s_d             = s_q;
        s_d.alarm.hit   = 1'b0;
        s_d.alarm.cause = CAUSE_BAD_RA;
        if (ovf) begin
            s_d.alarm.hit   = 1'b1;
            s_d.alarm.cause = CAUSE_OVERFLOW;
        end else if (unf) begin
            s_d.alarm.hit   = 1'b1;
            s_d.alarm.cause = CAUSE_UNDERFLOW;
        end else if (bad_wr) begin
            s_d.alarm.hit   = 1'b1;
            s_d.alarm.cause = CAUSE_BAD_RA;
        end else if (late) begin
            s_d.alarm.hit   = 1'b1;
            s_d.alarm.cause = CAUSE_TIMEOUT;
            mark            = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alarm_valid = s_q.alarm.hit;
    assign alarm_cause = s_q.alarm.cause;

endmodule

// File: rtl/cr_guard_chk.sv
module cr_guard_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        call_hit,
    input logic        ret_hit,
    input logic        ra_wr_valid,
    input logic        alarm_valid,
    input logic [1:0]  alarm_cause,
    input logic [DW:0] depth
);

    localparam logic [DW:0] FULL_CNT = (DW+1)'(DEPTH);

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (call_hit && depth < FULL_CNT) |=> (depth == $past(depth) + 1'b1)); // R1

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && depth != '0) |=> (depth == $past(depth) - 1'b1)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (call_hit && depth == FULL_CNT) |=> (alarm_valid && alarm_cause == 2'd2 && depth == FULL_CNT)); // R3

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= FULL_CNT); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_hit && depth == '0) |=> (alarm_valid && alarm_cause == 2'd3 && depth == '0)); // R4

    AST_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_wr_valid && !call_hit && !(ret_hit && depth == '0)) |=> (alarm_valid && alarm_cause == 2'd0)); // R5

    AST_LEGAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_wr_valid && call_hit && depth < FULL_CNT) |=> !alarm_valid); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_hit && !ret_hit) |=> $stable(depth)); // R9

endmodule

bind cr_guard cr_guard_chk #(
    .DEPTH(DEPTH),
    .DW   (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .call_hit   (call_hit),
    .ret_hit    (ret_hit),
    .ra_wr_valid(ra_wr_valid),
    .alarm_valid(alarm_valid),
    .alarm_cause(alarm_cause),
    .depth      (depth)
);

// File: tb/sim_cr_guard.sv
`timescale 1ns/1ps
module sim_cr_guard;

    localparam logic [31:0] OP_CALL = 32'h0000_00EF;
    localparam logic [31:0] OP_RET  = 32'h0000_8067;
    localparam logic [31:0] OP_NOP  = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_insn = '0;
    logic [31:0] fetch_pc = '0;
    logic        ra_wr_valid = 1'b0;
    logic [15:0] cfg_limit = 16'd20;
    logic        alarm_valid;
    logic [1:0]  alarm_cause;
    logic [4:0]  depth;
    logic [31:0] top_ret;

    always #2.5 clk = ~clk;

    cr_guard u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_valid(fetch_valid),
        .fetch_insn (fetch_insn),
        .fetch_pc   (fetch_pc),
        .ra_wr_valid(ra_wr_valid),
        .cfg_limit  (cfg_limit),
        .alarm_valid(alarm_valid),
        .alarm_cause(alarm_cause),
        .depth      (depth),
        .top_ret    (top_ret)
    );

    typedef struct {
        int unsigned ret;
        int unsigned start;
        bit          expd;
    } frm_t;

    frm_t        mq[$];
    int unsigned now_m = 0;
    bit          e_alarm;
    int          e_cause;
    int          n_run = 0;
    int          n_fail = 0;
    int          cyc_count = 0;
    string       phase = "R10";
    bit          last_tmo;
    bit          done = 1'b0;

    task automatic check(string tag, int act, int exp, string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(bit fv, logic [31:0] insn, logic [31:0] pc, bit raw);
        bit call, ret, ovf, unf, bad, tmo;
        call = fv && ((insn & 32'h7F) == 32'h6F);
        ret  = fv && !call && (insn == 32'h0000_8067);
        ovf = 0; unf = 0;
        tmo = !call && !ret && (mq.size() > 0) && !mq[$].expd &&
              (((now_m - mq[$].start) & 32'hFFFF) > cfg_limit);
        bad = raw && !call;
        if (call) begin
            if (mq.size() < 16) begin
                frm_t f;
                f.ret = pc + 4; f.start = now_m; f.expd = 0;
                mq.push_back(f);
            end else ovf = 1;
        end else if (ret) begin
            if (mq.size() == 0) unf = 1;
            else void'(mq.pop_back());
        end
        e_alarm = 1; e_cause = 0;
        if (ovf) e_cause = 2;
        else if (unf) e_cause = 3;
        else if (bad) e_cause = 0;
        else if (tmo) begin
            e_cause = 1;
            mq[$].expd = 1;
        end else e_alarm = 0;
        now_m = (now_m + 1) & 32'hFFFF;
    endtask

    task automatic cyc(bit fv, logic [31:0] insn, logic [31:0] pc, bit raw);
        @(negedge clk);
        fetch_valid = fv; fetch_insn = insn; fetch_pc = pc; ra_wr_valid = raw;
        model_step(fv, insn, pc, raw);
        @(posedge clk);
        #1.5;
        check(phase, alarm_valid, e_alarm, "alarm_valid");
        if (e_alarm) check(phase, alarm_cause, e_cause, "alarm_cause");
        check(phase, depth, mq.size(), "depth");
        check(phase, top_ret, (mq.size() > 0) ? mq[$].ret : 0, "top_ret");
        last_tmo = alarm_valid && alarm_cause == 2'd1;
    endtask

    task automatic do_call(logic [31:0] pc); cyc(1, OP_CALL, pc, 0); endtask
    task automatic do_ret(); cyc(1, OP_RET, 32'h0, 0); endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, OP_NOP, 32'h0, 0);
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc_count++;
            if (cyc_count > 20000) begin
                n_fail++;
                $display("FAIL ALL watchdog actual=hung expected=finished");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin : stim
        int tmo_at;
        int tmo_n;
        repeat (3) @(posedge clk);
        #1.5;
        // R10 reset state
        check("R10", alarm_valid, 0, "alarm after reset");
        check("R10", depth, 0, "depth after reset");
        check("R10", top_ret, 0, "top_ret after reset");
        @(negedge clk);
        rst_n = 1'b1;
        now_m = 0;

        phase = "R9";
        idle(3);
        cyc(1, OP_NOP, 32'h40, 0);
        cyc(1, 32'h0000_8063, 32'h44, 0);
        check("R9", depth, 0, "depth after non-matching fetch");

        phase = "R1";
        do_call(32'h100);
        check("R1", top_ret, 32'h104, "top_ret after call");
        do_call(32'h200);
        check("R1", depth, 2, "depth after nested call");
        phase = "R2";
        do_ret();
        check("R2", top_ret, 32'h104, "top_ret after pop");
        do_ret();
        check("R2", top_ret, 0, "top_ret when empty");

        phase = "R4";
        do_ret();
        check("R4", alarm_cause, 3, "underflow cause");

        phase = "R5";
        cyc(0, OP_NOP, 32'h0, 1);
        check("R5", alarm_valid, 1, "bad write alarm");
        cyc(1, OP_CALL, 32'h300, 1);
        check("R5", alarm_valid, 0, "write with call is legal");
        do_ret();

        phase = "R6";
        cfg_limit = 16'd20;
        do_call(32'h400);
        tmo_at = 0; tmo_n = 0;
        for (int i = 1; i <= 40; i++) begin
            idle(1);
            if (last_tmo) begin
                tmo_n++;
                if (tmo_at == 0) tmo_at = i;
            end
        end
        check("R6", tmo_at, 21, "timeout cycle after push");
        check("R6", tmo_n, 1, "timeout pulses per frame");
        do_ret();

        phase = "R7";
        do_call(32'h500);
        idle(5);
        do_call(32'h600);
        tmo_n = 0;
        for (int i = 0; i < 25; i++) begin
            idle(1);
            if (last_tmo) tmo_n++;
        end
        check("R7", tmo_n, 1, "only callee checked while open");
        do_ret();
        idle(1);
        check("R7", last_tmo, 1, "caller checked after callee returns");
        do_ret();

        phase = "R8";
        cyc(1, OP_RET, 32'h0, 1);
        check("R8", alarm_cause, 3, "underflow beats bad write");
        do_call(32'h700);
        idle(20);
        cyc(0, OP_NOP, 32'h0, 1);
        check("R8", alarm_cause, 0, "bad write beats timeout");
        idle(1);
        check("R8", last_tmo, 1, "deferred timeout next cycle");
        do_ret();

        phase = "R3";
        cfg_limit = 16'hFFFF;
        for (int i = 0; i < 16; i++) do_call(32'h1000 + 32'(i * 16));
        check("R3", depth, 16, "history full");
        do_call(32'h2000);
        check("R3", alarm_cause, 2, "overflow cause");
        check("R3", top_ret, 32'h10F4, "top kept on overflow");
        phase = "R2";
        for (int i = 0; i < 16; i++) do_ret();
        phase = "R4";
        do_ret();
        check("R4", depth, 0, "depth stays empty");
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule